// File: doc/BRIEF.md
# Byte Packing Buffer for a Serial Bus Data Port

This block sits between a 16-bit register data port and a byte-serial bus engine. It keeps a small shared byte store (four byte slots by default) with two independent fill counts, one for bytes waiting to be sent and one for bytes received. The host side pushes two bytes with a 16-bit write, or one byte with an 8-bit write, and pulls two received bytes with a 16-bit read. A big-endian control input sets the byte order of both the writes and the reads. The engine side pops transmit bytes one at a time, highest held slot first. It pushes received bytes into the store one at a time, lowest slot first.

Every host access produces single-cycle flag-update strobes for the surrounding status logic. An accepted write clears the transmit underflow flag, and it also clears transmit-ready once more than two bytes are queued. A read clears the receive overrun flag. When a read empties the receive side, it clears receive-ready; if the engine is then a receiving master, the read also raises access-ready and drops master mode. A read that finds only one byte held raises a dedicated single-byte strobe. The buffer holds none of these flags itself: the strobes are combinational and valid in the cycle of the access.

Top module: `pkb_pack_buffer`

## Requirements
- R1: After reset both fill counts are 0, the store holds all-zero slots, and every strobe is low while the host is idle.
- R2: A 16-bit write (host_wr16) with a transmit count of at most SLOTS-2 moves every slot up by two positions and adds 2 to the transmit count. With big_endian=1, wr_data[15:8] lands in slot 1 and wr_data[7:0] in slot 0. With big_endian=0, these two are swapped.
- R3: An 8-bit write (host_wr8) with a transmit count of at most SLOTS-2 moves every slot up by one position, puts wr_data[7:0] in slot 0 and adds 1 to the transmit count.
- R4: A write is refused when the transmit count exceeds SLOTS-2. A refused write leaves the store and the counts unchanged and raises no strobe.
- R5: An accepted write pulses xudf_clr. It also pulses xrdy_clr when the resulting transmit count exceeds 2.
- R6: tx_valid is high when the transmit count is nonzero, and tx_byte then shows the slot at index count-1. A tx_pop lowers the count by 1, and a pop at count 0 is refused.
- R7: An rx_push writes rx_byte into the slot at index rx count and adds 1 to the count. A push is refused when SLOTS bytes are held, and rx_ready is low exactly then.
- R8: rd_data shows slots 0 and 1. With big_endian=1, slot 0 is in bits 15:8 and slot 1 in bits 7:0. With big_endian=0, slot 1 is in bits 15:8 and slot 0 in bits 7:0.
- R9: A 16-bit read (host_rd16) with one byte held pulses single_byte_set and sets the rx count to 0. With two held, the count becomes 0. With more than two held, the slots move down by two and the count drops by 2.
- R10: Every read pulses rovr_clr. A read that leaves the rx count at 0 pulses rrdy_clr, and if master_rx is high it also pulses ardy_set and master_clr.
- R11: Host requests rank host_wr16 over host_wr8 over host_rd16. In one cycle the host access is applied first, and the engine pop and push then act on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr16 | input | 1 | 16-bit data write request |
| host_wr8 | input | 1 | 8-bit data write request |
| host_rd16 | input | 1 | 16-bit data read request |
| big_endian | input | 1 | Byte order select for writes and reads |
| wr_data | input | 2*BYTE_W | Write data |
| rd_data | output | 2*BYTE_W | Read data, slots 0 and 1 in chosen order |
| master_rx | input | 1 | Engine is a receiving master |
| tx_pop | input | 1 | Engine takes one transmit byte |
| tx_byte | output | BYTE_W | Next transmit byte |
| tx_valid | output | 1 | A transmit byte is available |
| rx_push | input | 1 | Engine delivers one received byte |
| rx_byte | input | BYTE_W | Received byte |
| rx_ready | output | 1 | Room for a received byte |
| tx_count | output | clog2(SLOTS+1) | Transmit fill count |
| rx_count | output | clog2(SLOTS+1) | Receive fill count |
| xudf_clr | output | 1 | Clear transmit underflow flag |
| xrdy_clr | output | 1 | Clear transmit ready flag |
| rrdy_clr | output | 1 | Clear receive ready flag |
| single_byte_set | output | 1 | Read found a single byte |
| ardy_set | output | 1 | Set access ready flag |
| master_clr | output | 1 | Leave master mode |
| rovr_clr | output | 1 | Clear receive overrun flag |

## Verification
The bench builds the block with its defaults, BYTE_W=8 and SLOTS=4. With these values a full store takes only two 16-bit writes or four pushes, so refused writes, refused pushes, pops at empty and reads of three or four bytes come up within a few cycles, both in the directed sequences and in the random traffic. A four-slot store also puts the transmit and receive sides on the same slots. This exposes how a write shifts received bytes and how a read shifts queued transmit bytes, and the behavioural model has to track both.

// File: rtl/pkb_pkg.sv
package pkb_pkg;
  typedef enum logic [1:0] {
    HOP_IDLE,
    HOP_WR16,
    HOP_WR8,
    HOP_RD16
  } host_op_e;
endpackage

// File: rtl/pkb_host_stage.sv
module pkb_host_stage #(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 4
) (
  input  pkb_pkg::host_op_e           op,
  input  logic                        big_endian,
  input  logic [2*BYTE_W-1:0]         wr_data,
  input  logic                        master_rx,
  input  logic [BYTE_W*SLOTS-1:0]     buf_q,
  input  logic [$clog2(SLOTS+1)-1:0]  txc_q,
  input  logic [$clog2(SLOTS+1)-1:0]  rxc_q,
  output logic [BYTE_W*SLOTS-1:0]     buf_h,
  output logic [$clog2(SLOTS+1)-1:0]  txc_h,
  output logic [$clog2(SLOTS+1)-1:0]  rxc_h,
  output logic [2*BYTE_W-1:0]         rd_data,
  output logic                        wr_accept,
  output logic                        xudf_clr,
  output logic                        xrdy_clr,
  output logic                        rrdy_clr,
  output logic                        single_set,
  output logic                        ardy_set,
  output logic                        master_clr,
  output logic                        rovr_clr
);
  localparam int BUF_W  = BYTE_W * SLOTS;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] TX_LIMIT = CNT_W'(SLOTS - 2);
  localparam logic [CNT_W-1:0] C_ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_TWO    = CNT_W'(2);

  // Exchange the two bytes of a host word.
  function automatic logic [WORD_W-1:0] swap_pair(input logic [WORD_W-1:0] w);
    return {w[BYTE_W-1:0], w[WORD_W-1:BYTE_W]};
  endfunction

  // Low word of the store as laid out by a 16-bit write.
  function automatic logic [WORD_W-1:0] pack_word(input logic [WORD_W-1:0] w,
                                                  input logic be);
    return be ? w : swap_pair(w);
  endfunction

  assign rd_data = big_endian ? swap_pair(buf_q[WORD_W-1:0]) : buf_q[WORD_W-1:0];

  always_comb begin
    buf_h      = buf_q;
    txc_h      = txc_q;
    rxc_h      = rxc_q;
    wr_accept  = 1'b0;
    xudf_clr   = 1'b0;
    xrdy_clr   = 1'b0;
    rrdy_clr   = 1'b0;
    single_set = 1'b0;
    ardy_set   = 1'b0;
    master_clr = 1'b0;
    rovr_clr   = 1'b0;
    unique case (op)
      pkb_pkg::HOP_WR16: begin
        if (txc_q <= TX_LIMIT) begin
          wr_accept = 1'b1;
          buf_h     = {buf_q[BUF_W-WORD_W-1:0], pack_word(wr_data, big_endian)};
          txc_h     = txc_q + C_TWO;
          xudf_clr  = 1'b1;
          xrdy_clr  = (txc_h > C_TWO);
        end
      end
      pkb_pkg::HOP_WR8: begin
        if (txc_q <= TX_LIMIT) begin
          wr_accept = 1'b1;
          buf_h     = {buf_q[BUF_W-BYTE_W-1:0], wr_data[BYTE_W-1:0]};
          txc_h     = txc_q + C_ONE;
          xudf_clr  = 1'b1;
          xrdy_clr  = (txc_h > C_TWO);
        end
      end
      pkb_pkg::HOP_RD16: begin
        rovr_clr = 1'b1;
        if (rxc_q == C_ONE) begin
          single_set = 1'b1;
          rxc_h      = '0;
        end else if (rxc_q >= C_TWO) begin
          if (rxc_q > C_TWO) buf_h = buf_q >> WORD_W;
          rxc_h = rxc_q - C_TWO;
        end
        if (rxc_h == '0) begin
          rrdy_clr   = 1'b1;
          ardy_set   = master_rx;
          master_clr = master_rx;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pkb_engine_stage.sv
module pkb_engine_stage #(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 4
) (
  input  logic [BYTE_W*SLOTS-1:0]     buf_h,
  input  logic [$clog2(SLOTS+1)-1:0]  txc_h,
  input  logic [$clog2(SLOTS+1)-1:0]  rxc_h,
  input  logic                        tx_pop,
  input  logic                        rx_push,
  input  logic [BYTE_W-1:0]           rx_byte,
  output logic [BYTE_W*SLOTS-1:0]     buf_n,
  output logic [$clog2(SLOTS+1)-1:0]  txc_n,
  output logic [$clog2(SLOTS+1)-1:0]  rxc_n,
  output logic [BYTE_W-1:0]           tx_byte,
  output logic                        tx_valid,
  output logic                        rx_ready,
  output logic                        pop_ok,
  output logic                        push_ok
);
  localparam int BUF_W = BYTE_W * SLOTS;
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(SLOTS);

  // Byte held at a given slot index.
  function automatic logic [BYTE_W-1:0] slot_of(input logic [BUF_W-1:0] b,
                                                input logic [CNT_W-1:0] idx);
    return BYTE_W'(b >> (int'(idx) * BYTE_W));
  endfunction

  assign tx_valid = (txc_h != '0);
  assign tx_byte  = tx_valid ? slot_of(buf_h, txc_h - C_ONE) : '0;
  assign rx_ready = (rxc_h < C_FULL);
  assign pop_ok   = tx_pop & tx_valid;
  assign push_ok  = rx_push & rx_ready;
  assign txc_n    = pop_ok  ? txc_h - C_ONE : txc_h;
  assign rxc_n    = push_ok ? rxc_h + C_ONE : rxc_h;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign buf_n[g*BYTE_W +: BYTE_W] =
      (push_ok && rxc_h == CNT_W'(g)) ? rx_byte : buf_h[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/pkb_pack_buffer.sv
module pkb_pack_buffer #(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_wr16,
  input  logic                        host_wr8,
  input  logic                        host_rd16,
  input  logic                        big_endian,
  input  logic [2*BYTE_W-1:0]         wr_data,
  output logic [2*BYTE_W-1:0]         rd_data,
  input  logic                        master_rx,
  input  logic                        tx_pop,
  output logic [BYTE_W-1:0]           tx_byte,
  output logic                        tx_valid,
  input  logic                        rx_push,
  input  logic [BYTE_W-1:0]           rx_byte,
  output logic                        rx_ready,
  output logic [$clog2(SLOTS+1)-1:0]  tx_count,
  output logic [$clog2(SLOTS+1)-1:0]  rx_count,
  output logic                        xudf_clr,
  output logic                        xrdy_clr,
  output logic                        rrdy_clr,
  output logic                        single_byte_set,
  output logic                        ardy_set,
  output logic                        master_clr,
  output logic                        rovr_clr
);
  localparam int BUF_W = BYTE_W * SLOTS;
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(SLOTS);

  logic [BUF_W-1:0] buf_q, buf_h, buf_n;
  logic [CNT_W-1:0] txc_q, rxc_q, txc_h, rxc_h, txc_n, rxc_n;
  logic             wr_accept, pop_ok, push_ok;
  pkb_pkg::host_op_e op;

  // Host request ranking (R11).
  always_comb begin
    if (host_wr16)      op = pkb_pkg::HOP_WR16;
    else if (host_wr8)  op = pkb_pkg::HOP_WR8;
    else if (host_rd16) op = pkb_pkg::HOP_RD16;
    else                op = pkb_pkg::HOP_IDLE;
  end

  pkb_host_stage #(.BYTE_W(BYTE_W), .SLOTS(SLOTS)) u_host (
    .op(op), .big_endian(big_endian), .wr_data(wr_data), .master_rx(master_rx),
    .buf_q(buf_q), .txc_q(txc_q), .rxc_q(rxc_q),
    .buf_h(buf_h), .txc_h(txc_h), .rxc_h(rxc_h), .rd_data(rd_data),
    .wr_accept(wr_accept), .xudf_clr(xudf_clr), .xrdy_clr(xrdy_clr),
    .rrdy_clr(rrdy_clr), .single_set(single_byte_set), .ardy_set(ardy_set),
    .master_clr(master_clr), .rovr_clr(rovr_clr)
  );

  pkb_engine_stage #(.BYTE_W(BYTE_W), .SLOTS(SLOTS)) u_engine (
    .buf_h(buf_h), .txc_h(txc_h), .rxc_h(rxc_h),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
    .buf_n(buf_n), .txc_n(txc_n), .rxc_n(rxc_n),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .rx_ready(rx_ready),
    .pop_ok(pop_ok), .push_ok(push_ok)
  );

  // R1: synchronous reset of store and counts.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      txc_q <= '0;
      rxc_q <= '0;
    end else begin
      buf_q <= buf_n;
      txc_q <= txc_n;
      rxc_q <= rxc_n;
    end
  end

  assign tx_count = txc_q;
  assign rx_count = rxc_q;

  assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= C_FULL);

  assert_refused_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_wr16 || host_wr8) && !wr_accept && !tx_pop && !rx_push)
      |=> ($stable(tx_count) && $stable(rx_count) && $stable(buf_q)));

  assert_xrdy_with_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xrdy_clr |-> (xudf_clr && wr_accept));

  assert_pop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (tx_count == $past(txc_h) - C_ONE));

  assert_rx_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == C_FULL && !host_wr16 && !host_wr8 && !host_rd16) |-> !rx_ready);

  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    single_byte_set |-> (rx_count == C_ONE && host_rd16));

  assert_ardy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ardy_set |-> (rrdy_clr && master_clr && master_rx && rovr_clr));
endmodule

// File: tb/sim_pkb_pack_buffer.sv
`timescale 1ns/1ps
module sim_pkb_pack_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr16 = 0, wr8 = 0, rd16 = 0, be = 0, mrx = 0, pop = 0, push = 0;
  logic [15:0] wd = '0;
  logic [7:0]  rxb = '0;
  logic [15:0] rd_data;
  logic [7:0]  tx_byte;
  logic        tx_valid, rx_ready;
  logic [2:0]  tx_count, rx_count;
  logic        xudf_clr, xrdy_clr, rrdy_clr, single_byte_set, ardy_set, master_clr, rovr_clr;

  int checks = 0;
  int fails  = 0;
  int mb[4];
  int mt = 0, mr = 0;
  int nb[4];
  int nt, nr;

  always #4 clk = ~clk;

  pkb_pack_buffer u0 (
    .clk(clk), .rst_n(rst_n), .host_wr16(wr16), .host_wr8(wr8), .host_rd16(rd16),
    .big_endian(be), .wr_data(wd), .rd_data(rd_data), .master_rx(mrx),
    .tx_pop(pop), .tx_byte(tx_byte), .tx_valid(tx_valid), .rx_push(push),
    .rx_byte(rxb), .rx_ready(rx_ready), .tx_count(tx_count), .rx_count(rx_count),
    .xudf_clr(xudf_clr), .xrdy_clr(xrdy_clr), .rrdy_clr(rrdy_clr),
    .single_byte_set(single_byte_set), .ardy_set(ardy_set),
    .master_clr(master_clr), .rovr_clr(rovr_clr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One clock of stimulus; the model predicts, compares and then commits.
  task automatic cyc(input logic w16, input logic w8, input logic r16, input logic e,
                     input logic [15:0] d, input logic m, input logic p,
                     input logic u, input logic [7:0] rb);
    int e_xudf = 0, e_xrdy = 0, e_rrdy = 0, e_sgl = 0, e_ardy = 0, e_mclr = 0, e_rovr = 0;
    int e_rd, e_tv, e_tb, e_rr;
    @(negedge clk);
    wr16 = w16; wr8 = w8; rd16 = r16; be = e; wd = d; mrx = m; pop = p; push = u; rxb = rb;
    #2;
    foreach (nb[i]) nb[i] = mb[i];
    nt = mt; nr = mr;
    e_rd = e ? (mb[0] * 256 + mb[1]) : (mb[1] * 256 + mb[0]);
    if (w16) begin
      if (mt <= 2) begin
        nb[3] = mb[1]; nb[2] = mb[0];
        if (e) begin nb[1] = d[15:8]; nb[0] = d[7:0]; end
        else   begin nb[1] = d[7:0];  nb[0] = d[15:8]; end
        nt = mt + 2; e_xudf = 1; e_xrdy = (nt > 2);
      end
    end else if (w8) begin
      if (mt <= 2) begin
        for (int i = 3; i > 0; i--) nb[i] = mb[i-1];
        nb[0] = d[7:0];
        nt = mt + 1; e_xudf = 1; e_xrdy = (nt > 2);
      end
    end else if (r16) begin
      e_rovr = 1;
      if (mr == 1) begin e_sgl = 1; nr = 0; end
      else if (mr >= 2) begin
        if (mr > 2) begin nb[0] = mb[2]; nb[1] = mb[3]; nb[2] = 0; nb[3] = 0; end
        nr = mr - 2;
      end
      if (nr == 0) begin e_rrdy = 1; e_ardy = m; e_mclr = m; end
    end
    e_tv = (nt > 0);
    e_tb = (nt > 0) ? nb[nt-1] : 0;
    e_rr = (nr < 4);
    if (p && nt > 0) nt--;
    if (u && nr < 4) begin nb[nr] = rb; nr++; end

    chk("R2 R3 R6 tx_count", tx_count, mt);
    chk("R7 R9 rx_count", rx_count, mr);
    chk("R8 rd_data", rd_data, e_rd);
    chk("R6 R11 tx_valid", tx_valid, e_tv);
    chk("R6 R11 tx_byte", tx_byte, e_tb);
    chk("R7 R11 rx_ready", rx_ready, e_rr);
    chk("R5 R4 xudf_clr", xudf_clr, e_xudf);
    chk("R5 xrdy_clr", xrdy_clr, e_xrdy);
    chk("R9 single_byte_set", single_byte_set, e_sgl);
    chk("R10 rrdy_clr", rrdy_clr, e_rrdy);
    chk("R10 ardy_set", ardy_set, e_ardy);
    chk("R10 master_clr", master_clr, e_mclr);
    chk("R10 rovr_clr", rovr_clr, e_rovr);
    @(posedge clk);
    foreach (mb[i]) mb[i] = nb[i];
    mt = nt; mr = nr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    foreach (mb[i]) mb[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 tx_count in reset", tx_count, 0);
    chk("R1 rx_count in reset", rx_count, 0);
    chk("R1 rd_data in reset", rd_data, 0);
    chk("R1 tx_valid in reset", tx_valid, 0);
    rst_n = 1'b1;
    cyc(0,0,0,0,16'h0,0,0,0,8'h0);                  // R1 idle, no strobes
    // R2 big-endian then little-endian word writes; R4 refusals when full
    cyc(1,0,0,1,16'hA1B2,0,0,0,8'h0);
    cyc(1,0,0,0,16'hC3D4,0,0,0,8'h0);
    cyc(1,0,0,1,16'h5555,0,0,0,8'h0);               // R4 refused
    cyc(0,1,0,1,16'h0066,0,0,0,8'h0);               // R4 refused byte
    for (int k = 0; k < 5; k++) cyc(0,0,0,0,16'h0,0,1,0,8'h0); // R6 pops, last at empty
    // R3 byte writes, R5 xrdy at count 3
    cyc(0,1,0,0,16'h0011,0,0,0,8'h0);
    cyc(0,1,0,0,16'h0022,0,0,0,8'h0);
    cyc(0,1,0,0,16'h0033,0,0,0,8'h0);
    cyc(1,1,1,0,16'h7788,0,1,0,8'h0);               // R11 wr16 ranks, pop same cycle
    for (int k = 0; k < 4; k++) cyc(0,0,0,0,16'h0,0,1,0,8'h0);
    // R7 pushes up to full and one refused
    for (int k = 0; k < 5; k++) cyc(0,0,0,0,16'h0,0,0,1,8'(8'h90 + k));
    cyc(0,0,1,1,16'h0,1,0,0,8'h0);                  // R9 read of four, R8 big-endian
    cyc(0,0,1,0,16'h0,1,0,1,8'hEE);                 // R11 read then push
    cyc(0,0,1,0,16'h0,1,0,0,8'h0);                  // R9 single byte, R10 ardy
    cyc(0,0,1,0,16'h0,1,0,0,8'h0);                  // R10 read at empty
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom % 8;
      cyc(r == 0, r == 1, r == 2 || r == 3, 1'($urandom), 16'($urandom),
          1'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0, 8'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule